// File: doc/BRIEF.md
# Configurable Registered Command Buffer

This block is a clocked register that sits between a memory controller's address and command lines and a module full of memory devices. On each rising clock edge it captures a parallel command word and presents it on its outputs. It runs in one of two layouts. In the wide layout, every input bit drives exactly one output. In the narrow layout, only the low input bits are used, and each captured bit drives two outputs, so one source can feed two device rows. A second configuration level picks one of two fixed arrangements for those output pairs.

Two active-low chip-select inputs gate the register. The outputs keep their values only when both selects are inactive (high). If either select is low, every edge captures new data. An active-low reset is fully asynchronous. It clears the register and drives every output low at once, without waiting for a clock edge, and it overrides the chip-select gating.

The command path has no back-pressure: a fresh word is offered on every edge, and the chip-selects are the only hold mechanism. For that reason there is no valid/ready pair, and every pin is a plain level.

Top module: `cmd_regbuf`

## Requirements
- R1: In the wide layout (`cfg_narrow`=0), a rising clock edge with either select low loads `din`, so `dout[i]` equals the `din[i]` sampled at that edge for every i below WIDE_W.
- R2: In the narrow layout (`cfg_narrow`=1), only `din[NARROW_W-1:0]` is used, and `din` bits at or above NARROW_W have no effect on `dout`.
- R3: Narrow arrangement A (`cfg_alt_map`=0): `dout[i]` and `dout[NARROW_W+i]` both carry the captured `din[i]`, for i below NARROW_W.
- R4: Narrow arrangement B (`cfg_alt_map`=1): `dout[2i]` and `dout[2i+1]` both carry the captured `din[i]`, for i below NARROW_W.
- R5: The setting `cfg_alt_map`=1 with `cfg_narrow`=0 is illegal and gives exactly the wide layout of R1.
- R6: A rising edge where `dcs_n` and `csr_n` are both high leaves `dout` unchanged.
- R7: While `csr_n` is low, every rising edge captures, whatever level `dcs_n` has.
- R8: Driving `rst_n` low forces `dout` to all zeros immediately, with no clock edge. It keeps `dout` at zero while it stays low, and it takes priority over the chip-selects.
- R9: After `rst_n` rises, `dout` stays zero until the first rising edge with a select low, and that edge loads fresh data.
- R10: In the wide layout, output bits at index WIDE_W and above are driven low.
- R11: The configuration levels are sampled on every capturing edge. A change made while the outputs are held does not alter `dout` until the next capturing edge, which applies the new mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all outputs |
| dcs_n | input | 1 | Active-low device chip-select |
| csr_n | input | 1 | Active-low secondary chip-select |
| cfg_narrow | input | 1 | 0 = wide one-to-one layout, 1 = narrow one-to-two layout |
| cfg_alt_map | input | 1 | Narrow-layout arrangement: 0 = A, 1 = B |
| din | input | WIDE_W | Command word to capture |
| dout | output | max(WIDE_W, 2*NARROW_W) | Registered, fanned-out command word |

## Verification
The bench builds the block with its defaults, WIDE_W=25 and NARROW_W=14. With these values the paired output (28 bits) is wider than the wide word, so the three top outputs are used only in the narrow layout. Those bits must drop to zero once a wide capture takes place. Because the two arrangements put one source bit on different output pairs, a mapping error shows up as a mismatch on specific output bits. Random command words are applied in every layout and in the illegal setting, with and without select gating. The bench also changes the configuration while the outputs are held and asserts reset between clock edges.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;

  typedef enum logic [1:0] {
    MAP_WIDE   = 2'd0,
    MAP_PAIR_A = 2'd1,
    MAP_PAIR_B = 2'd2
  } map_mode_e;

  // Output-to-source table: for output bit j in mode m, the input bit that
  // drives it, or -1 when the output is tied low.
  function automatic int src_bit(input map_mode_e m, input int j,
                                 input int wide_w, input int narrow_w);
    int r;
    r = -1;
    case (m)
      MAP_WIDE:   if (j < wide_w) r = j;
      MAP_PAIR_A: if (j < 2 * narrow_w) r = j % narrow_w;
      MAP_PAIR_B: if (j < 2 * narrow_w) r = j / 2;
      default:    r = -1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cmd_regbuf_cfg.sv
module cmd_regbuf_cfg
  import cmd_regbuf_pkg::*;
(
  input  logic      narrow,
  input  logic      alt_map,
  output map_mode_e mode
);
  // Illegal alt_map without narrow folds back to the wide layout.
  always_comb begin
    if (!narrow)      mode = MAP_WIDE;
    else if (alt_map) mode = MAP_PAIR_B;
    else              mode = MAP_PAIR_A;
  end
endmodule

// File: rtl/cmd_regbuf_fanout.sv
module cmd_regbuf_fanout
  import cmd_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
)(
  input  map_mode_e          mode,
  input  logic [WIDE_W-1:0]  din,
  output logic [OUT_W-1:0]   mapped
);
  for (genvar j = 0; j < OUT_W; j++) begin : g_bit
    localparam int SW = src_bit(MAP_WIDE,   j, WIDE_W, NARROW_W);
    localparam int SA = src_bit(MAP_PAIR_A, j, WIDE_W, NARROW_W);
    localparam int SB = src_bit(MAP_PAIR_B, j, WIDE_W, NARROW_W);
    logic bw, ba, bb;
    if (SW >= 0) begin : g_w
      assign bw = din[SW];
    end else begin : g_w0
      assign bw = 1'b0;
    end
    if (SA >= 0) begin : g_a
      assign ba = din[SA];
    end else begin : g_a0
      assign ba = 1'b0;
    end
    if (SB >= 0) begin : g_b
      assign bb = din[SB];
    end else begin : g_b0
      assign bb = 1'b0;
    end
    always_comb begin
      case (mode)
        MAP_PAIR_A: mapped[j] = ba;
        MAP_PAIR_B: mapped[j] = bb;
        default:    mapped[j] = bw;
      endcase
    end
  end
endmodule

// File: rtl/cmd_regbuf_capture.sv
module cmd_regbuf_capture #(
  parameter int W = 28
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
#(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  localparam int OUT_W   = (WIDE_W > 2 * NARROW_W) ? WIDE_W : 2 * NARROW_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dcs_n,
  input  logic              csr_n,
  input  logic              cfg_narrow,
  input  logic              cfg_alt_map,
  input  logic [WIDE_W-1:0] din,
  output logic [OUT_W-1:0]  dout
);
  map_mode_e          mode;
  logic [OUT_W-1:0]   mapped;
  logic               load;

  assign load = ~(dcs_n & csr_n);

  cmd_regbuf_cfg u_cfg (
    .narrow  (cfg_narrow),
    .alt_map (cfg_alt_map),
    .mode    (mode)
  );

  cmd_regbuf_fanout #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_map (
    .mode   (mode),
    .din    (din),
    .mapped (mapped)
  );

  cmd_regbuf_capture #(.W(OUT_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (mapped),
    .q     (dout)
  );
endmodule

// File: rtl/cmd_regbuf_chk.sv
module cmd_regbuf_chk #(
  parameter int WIDE_W   = 25,
  parameter int NARROW_W = 14,
  parameter int OUT_W    = 28
)(
  input logic              clk,
  input logic              rst_n,
  input logic              dcs_n,
  input logic              csr_n,
  input logic              cfg_narrow,
  input logic              cfg_alt_map,
  input logic [WIDE_W-1:0] din,
  input logic [OUT_W-1:0]  dout
);
  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEARS: assert (dout == '0); // R8
  end

  AST_HOLD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dcs_n && csr_n) |=> $stable(dout)); // R6

  AST_WIDE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dcs_n && csr_n) && !cfg_narrow) |=> (dout[WIDE_W-1:0] == $past(din))); // R1

  AST_CSR_LOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_n && !cfg_narrow) |=> (dout[WIDE_W-1:0] == $past(din))); // R7

  AST_PAIR_A_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dcs_n && csr_n) && cfg_narrow && !cfg_alt_map) |=>
      (dout[NARROW_W-1:0] == dout[2*NARROW_W-1:NARROW_W])); // R3

  for (genvar k = 0; k < NARROW_W; k++) begin : g_pb
    AST_PAIR_B_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      (!(dcs_n && csr_n) && cfg_narrow && cfg_alt_map) |=>
        (dout[2*k] == dout[2*k+1])); // R4
  end

  if (OUT_W > WIDE_W) begin : g_hi
    AST_WIDE_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!(dcs_n && csr_n) && !cfg_narrow) |=> (dout[OUT_W-1:WIDE_W] == '0)); // R10
  end
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dcs_n(dcs_n), .csr_n(csr_n),
  .cfg_narrow(cfg_narrow), .cfg_alt_map(cfg_alt_map), .din(din), .dout(dout)
);

// File: tb/cmd_regbuf_bench.sv
`timescale 1ns/1ps
module cmd_regbuf_bench;
  localparam int WW = 25;
  localparam int NW = 14;
  localparam int OW = 28;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dcs_n = 1'b1, csr_n = 1'b1;
  logic          cfg_narrow = 1'b0, cfg_alt_map = 1'b0;
  logic [WW-1:0] din = '0;
  logic [OW-1:0] dout;
  logic [OW-1:0] exp_q = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmd_regbuf u_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .dcs_n(dcs_n), .csr_n(csr_n),
    .cfg_narrow(cfg_narrow), .cfg_alt_map(cfg_alt_map), .din(din), .dout(dout)
  );

  // Expected output word from the requirement mappings.
  function automatic logic [OW-1:0] model(input logic [WW-1:0] d, input logic nar, input logic alt);
    logic [OW-1:0] r;
    r = '0;
    if (!nar) begin
      for (int i = 0; i < WW; i++) r[i] = d[i];
    end else if (!alt) begin
      for (int i = 0; i < NW; i++) begin r[i] = d[i]; r[NW+i] = d[i]; end
    end else begin
      for (int i = 0; i < NW; i++) begin r[2*i] = d[i]; r[2*i+1] = d[i]; end
    end
    return r;
  endfunction

  task automatic chk(input logic [OW-1:0] e, input string tag);
    total++;
    if (dout !== e) begin
      bad++;
      $display("FAIL %s dout=%h expected=%h", tag, dout, e);
    end
  endtask

  // One clock: update model at the rising edge, compare at the falling edge.
  task automatic step(input string tag);
    @(posedge clk);
    if (rst_n && !(dcs_n && csr_n)) exp_q = model(din, cfg_narrow, cfg_alt_map);
    @(negedge clk);
    chk(exp_q, tag);
  endtask

  task automatic rnd_steps(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      din = WW'($urandom);
      step(tag);
    end
  endtask

  initial begin
    @(negedge clk);
    chk('0, "R8 reset state");
    dcs_n = 1'b0; din = '1;
    step("R8 reset overrides select");
    @(negedge clk);
    rst_n = 1'b1; dcs_n = 1'b1; csr_n = 1'b1; din = '1;
    step("R9 held low after release");
    step("R9 held low after release");
    dcs_n = 1'b0; din = WW'(25'h0A5_5A5A);
    step("R9 first selected edge loads");

    cfg_narrow = 1'b0; cfg_alt_map = 1'b0;
    rnd_steps(12, "R1,R10 wide layout");
    din = '1; step("R1,R10 wide all ones");

    cfg_alt_map = 1'b1;
    rnd_steps(10, "R5 illegal setting acts wide");

    cfg_narrow = 1'b1; cfg_alt_map = 1'b0;
    rnd_steps(10, "R3 narrow arrangement A");
    din = WW'(25'h1FF_C000); step("R2 upper bits ignored");

    cfg_alt_map = 1'b1;
    rnd_steps(10, "R4 narrow arrangement B");
    din = WW'(25'h000_2001); step("R4 end bits");
    din = WW'(25'h1FF_C000); step("R2 upper bits ignored B");

    dcs_n = 1'b1; csr_n = 1'b1;
    rnd_steps(6, "R6 both selects high hold");
    cfg_narrow = 1'b0; cfg_alt_map = 1'b0;
    rnd_steps(3, "R11 config change while held");
    dcs_n = 1'b0;
    rnd_steps(2, "R11 new mapping at capture");

    csr_n = 1'b0; dcs_n = 1'b1;
    rnd_steps(8, "R7 csr low, dcs high");
    dcs_n = 1'b0; csr_n = 1'b1;
    rnd_steps(4, "R7 dcs low, csr high");

    din = '1; step("R8 preload");
    #5 rst_n = 1'b0;
    #1 chk('0, "R8 asynchronous clear");
    exp_q = '0;
    step("R8 stays clear");
    @(negedge clk);
    rst_n = 1'b1; dcs_n = 1'b1; csr_n = 1'b1;
    step("R9 hold after second release");
    dcs_n = 1'b0;
    rnd_steps(3, "R9 capture resumes");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule